// File: doc/BRIEF.md
# Flash Row Write-Buffer Controller

This block is the write path into a flash program memory. Software streams single bytes into a row of holding registers. A byte pointer picks the slot and can step forward after each byte. Filling a slot is a short write: only the buffer changes and the memory array stays as it was. The array changes only when a separate control port fires a long write. That long write lasts a fixed number of clock cycles and stalls the processor while it runs. When it ends, every byte of the selected row becomes the AND of its old value and its holding byte.

A long write is protected by an unlock key. The key port must first see 55h and then AAh. The control write that follows must request the start with write-enable and program-memory select both set. Any other access in between cancels the key: a different key value, a byte load or a pointer write. A start request that is turned down writes nothing and sets a sticky error flag. Holding bytes go back to FFh at reset and after each finished long write, so slots that were never loaded leave their memory bytes unchanged. The memory array is a behavioural model, cleared to FFh at reset, and the bench reads it through a plain read port.

Top module: `prog_row_writer`

## Requirements
- R1: The buffer has ROW_BYTES (32) holding bytes. A byte load writes the slot named by ptr_q[4:0]. A load changes no memory byte until a long write completes.
- R2: Every holding byte is FFh after reset and after each completed long write. The memory array is FFh after reset. A holding byte of FFh leaves its memory byte unchanged.
- R3: A completed long write sets each byte of the selected row to (old memory byte) AND (holding byte). No memory bit ever goes from 0 to 1.
- R4: ptr_wr loads ptr_q from ptr_wdata. A byte load with ld_inc=1 adds one to ptr_q, wrapping over the full address width. A byte load with ld_inc=0 leaves ptr_q unchanged.
- R5: A start is accepted only when the two key writes just before the control write were 55h and then AAh. A wrong key value, a byte load or a pointer write in between cancels the unlock. Every control write uses up the unlock.
- R6: A start request that is turned down writes no memory and does not raise stall. It sets start_err to 1. start_err stays at 1 until a start is accepted, and an accepted start clears it.
- R7: A start request with cfg_wen=0 or cfg_psel=0 is turned down even after a valid unlock.
- R8: After an accepted start, stall is high for exactly PROG_CYCLES cycles, beginning in the cycle after the control write. While stall is high, byte loads, pointer writes, key writes and control writes are ignored.
- R9: done is a one-cycle pulse in the cycle after the last stall cycle. The memory update is visible in that same cycle.
- R10: The row that is programmed is ptr_q[ADDR_W-1:5], sampled when the start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | Byte load into the holding slot at ptr_q |
| ld_data | input | 8 | Byte to load |
| ld_inc | input | 1 | Step the pointer after this load |
| ptr_wr | input | 1 | Load the byte pointer |
| ptr_wdata | input | ADDR_W | New pointer value |
| key_wr | input | 1 | Write to the unlock key port |
| key_data | input | 8 | Key value |
| cfg_wr | input | 1 | Control write |
| cfg_wen | input | 1 | Write-enable field of the control write |
| cfg_psel | input | 1 | Program-memory select field of the control write |
| cfg_start | input | 1 | Start-request field of the control write |
| rd_addr | input | ADDR_W | Read address into the memory model |
| rd_data | output | 8 | Memory byte at rd_addr (combinational) |
| ptr_q | output | ADDR_W | Current byte pointer |
| stall | output | 1 | Long write in progress; the processor is halted |
| done | output | 1 | One-cycle pulse when a long write completes |
| start_err | output | 1 | Sticky flag: a start request was turned down |

## Verification
The long write is tried with four kinds of row: a row with nothing loaded, which shows that FFh slots protect memory; a fully loaded row, which shows the slot mapping and the pointer stepping; a row programmed twice, which shows that the result is an AND and not a plain write; and random partial loads under random pointers. The unlock is tried with a correct key, a wrong second key, a lone AAh, and a byte load or pointer write placed between the keys. It is also tried with write-enable or select clear. Together these separate a rejection caused by the key from a rejection caused by the gating. Loads and pointer writes issued during the stall show whether the frozen state really is frozen, and the row the bench picks each time checks which pointer bits choose the block.

// File: rtl/fwb_pkg.sv
// Package fwb_pkg
// Shared constants and types for the flash row write-buffer controller.
// Assumes: the key values are fixed and do not depend on any parameter.
package fwb_pkg;
    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        UL_IDLE  = 2'd0,
        UL_HALF  = 2'd1,
        UL_ARMED = 2'd2
    } unlock_t;
endpackage

// File: rtl/fwb_hold_buf.sv
// Module fwb_hold_buf
// A row of byte-wide holding registers. One slot is written per cycle, and the
// whole row returns to FFh on clear.
// Assumes: clear and write never come in the same cycle; if they do, clear wins.
module fwb_hold_buf #(
    parameter int ROW_BYTES = 32,
    localparam int IDX_W = $clog2(ROW_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [7:0]             wr_data,
    input  logic                   clr,
    output logic [ROW_BYTES*8-1:0] bytes_flat
);
    for (genvar g = 0; g < ROW_BYTES; g++) begin : g_slot
        logic [7:0] slot_q;

        // Slot register: FFh on reset or clear, otherwise written when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                slot_q <= 8'hFF;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_q <= wr_data;
            end
        end

        assign bytes_flat[g*8 +: 8] = slot_q;
    end
endmodule

// File: rtl/fwb_unlock_det.sv
// Module fwb_unlock_det
// Watches the key port for 55h followed by AAh. Any other access cancels the
// sequence, and every control write uses it up.
// Assumes: while block is high, all accesses are ignored and the state is held.
module fwb_unlock_det
    import fwb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       block,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    input  logic       disturb,
    input  logic       consume,
    output logic       armed
);
    unlock_t state_q;

    // Unlock sequencer: step on correct keys, drop to idle on anything else.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= UL_IDLE;
        end else if (!block) begin
            if (disturb || consume) begin
                state_q <= UL_IDLE;
            end else if (key_wr) begin
                if (state_q == UL_IDLE && key_data == KEY_FIRST) begin
                    state_q <= UL_HALF;
                end else if (state_q == UL_HALF && key_data == KEY_SECOND) begin
                    state_q <= UL_ARMED;
                end else begin
                    state_q <= UL_IDLE;
                end
            end
        end
    end

    assign armed = (state_q == UL_ARMED);
endmodule

// File: rtl/fwb_prog_timer.sv
// Module fwb_prog_timer
// Times a long write. After start it keeps run high for CYCLES cycles and
// raises expire in the last of them.
// Assumes: start is only pulsed while run is low; CYCLES >= 1.
module fwb_prog_timer #(
    parameter int CYCLES = 400000,
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic run,
    output logic expire
);
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    // Countdown: load on start, step down each running cycle, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= CNT_W'(CYCLES - 1);
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign run    = run_q;
    assign expire = run_q && (cnt_q == '0);
endmodule

// File: rtl/prog_row_writer.sv
// Module prog_row_writer
// Flash row write-buffer controller. It has the byte pointer, the holding row,
// the unlock check, the start gating, the programming timer and a behavioural
// memory that can only clear bits.
// Assumes: ADDR_W > log2(ROW_BYTES); the processor issues no accesses while stall is high.
module prog_row_writer #(
    parameter int ADDR_W      = 8,
    parameter int ROW_BYTES   = 32,
    parameter int PROG_CYCLES = 400000,
    localparam int IDX_W     = $clog2(ROW_BYTES),
    localparam int BLK_W     = ADDR_W - IDX_W,
    localparam int MEM_BYTES = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [7:0]        ld_data,
    input  logic              ld_inc,
    input  logic              ptr_wr,
    input  logic [ADDR_W-1:0] ptr_wdata,
    input  logic              key_wr,
    input  logic [7:0]        key_data,
    input  logic              cfg_wr,
    input  logic              cfg_wen,
    input  logic              cfg_psel,
    input  logic              cfg_start,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] ptr_q,
    output logic              stall,
    output logic              done,
    output logic              start_err
);
    logic                   busy;
    logic                   expire;
    logic                   unlock_armed;
    logic                   start_req;
    logic                   start_ok;
    logic                   start_bad;
    logic [ROW_BYTES*8-1:0] hold_flat;
    logic [BLK_W-1:0]       blk_q;
    logic [ADDR_W-1:0]      ptr_r;
    logic                   done_q;
    logic                   err_q;
    logic [7:0]             mem_q [MEM_BYTES];

    // Start gating: unlock, write-enable and select must all hold when the start is requested.
    always_comb begin
        start_req = cfg_wr && cfg_start && !busy;
        start_ok  = start_req && unlock_armed && cfg_wen && cfg_psel;
        start_bad = start_req && !start_ok;
    end

    fwb_hold_buf #(.ROW_BYTES(ROW_BYTES)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ld_valid && !busy),
        .wr_idx     (ptr_r[IDX_W-1:0]),
        .wr_data    (ld_data),
        .clr        (expire),
        .bytes_flat (hold_flat)
    );

    fwb_unlock_det u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .block    (busy),
        .key_wr   (key_wr),
        .key_data (key_data),
        .disturb  (ld_valid || ptr_wr),
        .consume  (cfg_wr),
        .armed    (unlock_armed)
    );

    fwb_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_ok),
        .run    (busy),
        .expire (expire)
    );

    // Byte pointer: explicit load wins; otherwise step after an incrementing load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_r <= '0;
        end else if (!busy) begin
            if (ptr_wr) begin
                ptr_r <= ptr_wdata;
            end else if (ld_valid && ld_inc) begin
                ptr_r <= ptr_r + 1'b1;
            end
        end
    end

    // Target row: capture the block bits of the pointer when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q <= '0;
        end else if (start_ok) begin
            blk_q <= ptr_r[ADDR_W-1:IDX_W];
        end
    end

    // Status: one-cycle done at timer expiry, sticky error until an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= expire;
            if (start_ok) begin
                err_q <= 1'b0;
            end else if (start_bad) begin
                err_q <= 1'b1;
            end
        end
    end

    // Memory model: erased at reset; at expiry the selected row is ANDed with the holding bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < MEM_BYTES; a++) begin
                mem_q[a] <= 8'hFF;
            end
        end else if (expire) begin
            for (int i = 0; i < ROW_BYTES; i++) begin
                mem_q[{blk_q, IDX_W'(i)}] <= mem_q[{blk_q, IDX_W'(i)}] & hold_flat[i*8 +: 8];
            end
        end
    end

    assign rd_data   = mem_q[rd_addr];
    assign ptr_q     = ptr_r;
    assign stall     = busy;
    assign done      = done_q;
    assign start_err = err_q;
endmodule

// File: rtl/fwb_checker.sv
// Module fwb_checker
// Properties for prog_row_writer, attached to it with bind.
// Assumes: it sees the ports of the top module plus the unlock flag and the holding row.
module fwb_checker #(
    parameter int ADDR_W      = 8,
    parameter int ROW_BYTES   = 32,
    parameter int PROG_CYCLES = 400000,
    localparam int RUN_W = $clog2(PROG_CYCLES + 1) + 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_wr,
    input logic                   cfg_start,
    input logic                   cfg_wen,
    input logic                   cfg_psel,
    input logic                   armed,
    input logic                   stall,
    input logic                   done,
    input logic                   start_err,
    input logic [ADDR_W-1:0]      rd_addr,
    input logic [7:0]             rd_data,
    input logic [ADDR_W-1:0]      ptr_q,
    input logic [ROW_BYTES*8-1:0] hold_flat
);
    logic [RUN_W-1:0] run_cnt;

    // Run counter: number of stall cycles seen so far in the current long write.
    always_ff @(posedge clk) begin
        if (!rst_n || !stall) begin
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    a_r8_stall_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (run_cnt < RUN_W'(PROG_CYCLES)));

    a_r8_stall_full_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> ($past(run_cnt) == RUN_W'(PROG_CYCLES - 1)));

    a_r8_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(ptr_q));

    a_r9_done_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(stall) && !stall));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_refused_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_start && !stall && !armed) |=> (!stall && start_err));

    a_r7_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_start && !stall && !(cfg_wen && cfg_psel)) |=> !stall);

    a_r3_no_rising_bits: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(rd_addr) |-> ((rd_data & ~$past(rd_data)) == 8'h00));

    a_r2_hold_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (&hold_flat));
endmodule

bind prog_row_writer fwb_checker #(
    .ADDR_W      (ADDR_W),
    .ROW_BYTES   (ROW_BYTES),
    .PROG_CYCLES (PROG_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_start (cfg_start),
    .cfg_wen   (cfg_wen),
    .cfg_psel  (cfg_psel),
    .armed     (unlock_armed),
    .stall     (stall),
    .done      (done),
    .start_err (start_err),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .ptr_q     (ptr_q),
    .hold_flat (hold_flat)
);

// File: tb/prog_row_writer_tb.sv
`timescale 1ns/1ps
module prog_row_writer_tb;
    localparam int AW  = 8;
    localparam int RB  = 32;
    localparam int PC  = 24;
    localparam int MB  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ld_valid = 0, ld_inc = 0, ptr_wr = 0, key_wr = 0;
    logic          cfg_wr = 0, cfg_wen = 0, cfg_psel = 0, cfg_start = 0;
    logic [7:0]    ld_data = 0, key_data = 0;
    logic [AW-1:0] ptr_wdata = 0, rd_addr = 0;
    logic [7:0]    rd_data;
    logic [AW-1:0] ptr_q;
    logic          stall, done, start_err;

    int checks = 0;
    int errors = 0;
    logic [7:0]    m_mem [MB];
    logic [7:0]    m_hold [RB];
    logic [AW-1:0] m_ptr;
    logic [AW-1:0] m_start_ptr;

    always #2.5 clk = ~clk;

    prog_row_writer #(.ADDR_W(AW), .ROW_BYTES(RB), .PROG_CYCLES(PC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_data(ld_data), .ld_inc(ld_inc),
        .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .key_wr(key_wr), .key_data(key_data),
        .cfg_wr(cfg_wr), .cfg_wen(cfg_wen), .cfg_psel(cfg_psel), .cfg_start(cfg_start),
        .rd_addr(rd_addr), .rd_data(rd_data), .ptr_q(ptr_q), .stall(stall), .done(done),
        .start_err(start_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Expected row result: old byte AND holding byte, across the block the start pointer names.
    function automatic logic [7:0] merged(input logic [7:0] old_b, input logic [7:0] hold_b);
        return old_b & hold_b;
    endfunction

    task automatic model_commit();
        for (int i = 0; i < RB; i++) begin
            int a;
            a = {m_start_ptr[AW-1:5], 5'(i)};
            m_mem[a] = merged(m_mem[a], m_hold[i]);
            m_hold[i] = 8'hFF;
        end
    endtask

    // All tasks start just after a falling edge and return just after one.
    task automatic load_byte(input logic [7:0] d, input logic inc);
        ld_valid = 1; ld_data = d; ld_inc = inc;
        @(negedge clk);
        ld_valid = 0; ld_inc = 0;
        m_hold[m_ptr[4:0]] = d;
        if (inc) m_ptr = m_ptr + 1'b1;
    endtask

    task automatic set_ptr(input logic [AW-1:0] a);
        ptr_wr = 1; ptr_wdata = a;
        @(negedge clk);
        ptr_wr = 0;
        m_ptr = a;
    endtask

    task automatic key(input logic [7:0] v);
        key_wr = 1; key_data = v;
        @(negedge clk);
        key_wr = 0;
    endtask

    task automatic cfg(input logic w, input logic p, input logic s);
        cfg_wr = 1; cfg_wen = w; cfg_psel = p; cfg_start = s;
        @(negedge clk);
        cfg_wr = 0; cfg_wen = 0; cfg_psel = 0; cfg_start = 0;
    endtask

    task automatic expect_refused(input string tag);
        check({tag, " stall after refused start"}, stall, 1'b0);
        check({tag, " start_err after refused start"}, start_err, 1'b1);
    endtask

    // Accepted start: unlock, request, then time the stall and the done pulse.
    task automatic program_row(input string tag, input logic busy_poke);
        int n;
        key(8'h55);
        key(8'hAA);
        m_start_ptr = m_ptr;
        cfg(1, 1, 1);
        check({tag, " R6 start_err cleared by accepted start"}, start_err, 1'b0);
        n = 0;
        while (stall && n < PC + 4) begin
            if (busy_poke && n == 2) begin
                ld_valid = 1; ld_data = 8'h00; ld_inc = 1;
                ptr_wr = 0;
            end else if (busy_poke && n == 3) begin
                ld_valid = 0; ld_inc = 0;
                ptr_wr = 1; ptr_wdata = ~m_ptr;
            end else begin
                ld_valid = 0; ld_inc = 0; ptr_wr = 0;
            end
            n++;
            @(negedge clk);
            if (busy_poke && stall) check({tag, " R8 pointer frozen during stall"}, ptr_q, m_ptr);
        end
        ld_valid = 0; ld_inc = 0; ptr_wr = 0;
        check({tag, " R8 stall length"}, n, PC);
        check({tag, " R9 done after stall"}, done, 1'b1);
        model_commit();
        rd_addr = {m_start_ptr[AW-1:5], 5'd0};
        #0.5;
        check({tag, " R9 memory updated with done"}, rd_data, m_mem[rd_addr]);
        @(negedge clk);
        check({tag, " R9 done single cycle"}, done, 1'b0);
    endtask

    task automatic verify_mem(input string tag);
        for (int a = 0; a < MB; a++) begin
            rd_addr = AW'(a);
            #0.1;
            check(tag, rd_data, m_mem[a]);
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17C3E1));
        for (int a = 0; a < MB; a++) m_mem[a] = 8'hFF;
        for (int i = 0; i < RB; i++) m_hold[i] = 8'hFF;
        m_ptr = '0;
        rst_n = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        check("R8 stall low after reset", stall, 1'b0);
        check("R9 done low after reset", done, 1'b0);
        check("R6 start_err low after reset", start_err, 1'b0);
        check("R4 pointer zero after reset", ptr_q, 0);
        verify_mem("R2 memory erased after reset");

        // R2: nothing loaded since reset, so the row must stay as it was.
        set_ptr(8'h47);
        program_row("R2 empty row", 1'b0);
        verify_mem("R2 FFh slots leave memory unchanged");

        // R1, R4, R10: fill one row with stepping, memory untouched until programmed.
        set_ptr(8'h20);
        for (int i = 0; i < RB; i++) load_byte(8'(8'hF0 ^ (i * 7)), 1'b1);
        check("R4 pointer stepped 32 times", ptr_q, 8'h40);
        verify_mem("R1 loads do not touch memory");
        set_ptr(8'h3B);
        program_row("R10 row from block bits", 1'b0);
        verify_mem("R1 R10 full row programmed");

        // R4: loads without stepping overwrite one slot.
        set_ptr(8'h25);
        load_byte(8'h3C, 1'b0);
        load_byte(8'h0F, 1'b0);
        check("R4 pointer holds without ld_inc", ptr_q, 8'h25);
        load_byte(8'hE7, 1'b1);
        check("R4 pointer steps with ld_inc", ptr_q, 8'h26);
        set_ptr(8'h20);
        program_row("R3 second pass", 1'b0);
        verify_mem("R3 result is AND of old and new");

        // R5, R6: broken unlock sequences.
        key(8'h55); key(8'h12); key(8'hAA); cfg(1, 1, 1);
        expect_refused("R5 wrong middle key");
        key(8'hAA); cfg(1, 1, 1);
        expect_refused("R5 lone second key");
        set_ptr(8'h80);
        key(8'h55); load_byte(8'h77, 1'b0); key(8'hAA); cfg(1, 1, 1);
        expect_refused("R5 load between keys");
        key(8'h55); key(8'hAA); set_ptr(8'h80); cfg(1, 1, 1);
        expect_refused("R5 pointer write after keys");
        verify_mem("R6 refused starts write nothing");
        check("R6 start_err still set", start_err, 1'b1);

        // R7: gating clear after a correct unlock.
        key(8'h55); key(8'hAA); cfg(0, 1, 1);
        expect_refused("R7 write-enable clear");
        key(8'h55); key(8'hAA); cfg(1, 0, 1);
        expect_refused("R7 select clear");
        cfg(1, 1, 1);
        expect_refused("R5 unlock used by earlier control write");
        verify_mem("R7 gated starts write nothing");

        // R8: accesses during the stall are ignored.
        program_row("R8 busy accesses", 1'b1);
        verify_mem("R8 stall-time loads ignored");

        // Random rows with partial loads.
        for (int r = 0; r < 6; r++) begin
            int cnt;
            set_ptr(AW'($urandom));
            cnt = 1 + ($urandom % 40);
            for (int k = 0; k < cnt; k++) begin
                load_byte(8'($urandom | $urandom), (($urandom % 8) != 0));
            end
            program_row("R3 random row", 1'b0);
            verify_mem("R3 random row memory");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule